// File: doc/BRIEF.md
# Dual-Plane Palette Index Generator

This block turns two bitmap bytes, fetched side by side over a 16-bit video data path, into a stream of palette indices, one per output pixel. Each byte belongs to its own plane. Each plane has its own resolution setting. A coarse setting gives four bits per pixel, a middle setting gives two bits and a fine setting gives one bit. The bit fields of the two planes are joined into one index. Plane A supplies the low bits and plane B sits directly above them. Mixed settings therefore give the following mixed-resolution colour modes:

- A middle with B coarse: 64 colours, where the 4-bit part is shared by each pixel pair.
- A fine with B middle: 8 colours, with colour clash per pixel pair.
- A fine with B coarse: 32 colours at high resolution.
- Both coarse: full 8-bit colour.

With plane B switched off, plane A behaves as a classic single-plane display.

A pixel-clock enable runs at the finest pixel rate. A load strobe is honoured together with that enable. It captures both bytes, both mode selects and the plane-B enable, and restarts the group of eight pixel slots. The index is registered and emitted together with a valid flag.

Top module: `pal_index_gen`

## Requirements
- R1: When `load` is high on a clock edge that has `pix_en` high, slot s (0..7) of the captured byte pair appears on `pix_index`/`pix_valid` right after the (s+1)-th later edge with `pix_en` high, with `pix_valid` = 1.
- R2: A load taken in the middle of a group abandons the remaining slots and starts again at slot 0 with the new bytes.
- R3: Both outputs change only on clock edges where `pix_en` is high.
- R4: Mode code 2 (fine) gives a 1-bit field. Slot s uses byte bit 7-s.
- R5: Mode code 1 (middle) gives a 2-bit field. Pixel n = s/2 is held for two slots, and its value is {bit 3-n, bit 7-n}, most significant first.
- R6: Mode codes 0 and 3 (coarse) give a 4-bit field. Pixel n = s/4 is held for four slots. Pixel 0 is {bit1, bit5, bit3, bit7} and pixel 1 is {bit0, bit4, bit2, bit6}, most significant first.
- R7: The index is plane A's field in the low bits. Plane B's field follows starting at bit position width(A). All higher bits are 0.
- R8: When the captured plane-B enable is 0, plane B adds nothing, and the index equals plane A's field alone.
- R9: Bytes, mode selects and the plane-B enable are sampled only at an honoured load. Changes between loads have no effect on the current group.
- R10: After eight slots with no new load, every further `pix_en` edge gives `pix_valid` = 0 and `pix_index` = 0 until the next load.
- R11: `load` on an edge with `pix_en` low is ignored.
- R12: After reset `pix_valid` and `pix_index` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable at the finest pixel rate |
| load | input | 1 | Capture strobe for a new byte pair (honoured only with pix_en) |
| plane_a_byte | input | 8 | Bitmap byte for plane A |
| plane_b_byte | input | 8 | Bitmap byte for plane B |
| mode_a | input | 2 | Plane A mode: 0/3 coarse, 1 middle, 2 fine |
| mode_b | input | 2 | Plane B mode, same coding |
| plane_b_on | input | 1 | Plane B contributes to the index when 1 |
| pix_index | output | 8 | Registered palette index |
| pix_valid | output | 1 | Index belongs to a loaded byte pair |

## Verification
The load edge holds the captured values in the plane registers. The output register then takes slot s on the (s+1)-th following enabled edge. With `pix_en` held high, slot 0 is therefore visible one clock after the load edge and slot 7 eight clocks after it. The clock edge that follows slot 7 brings `pix_valid` low when no new load has come. The bench keeps a behavioural model that updates on the same edges and compares both outputs at every falling edge. The directed groups sample at the falling edge two clocks after the load is driven, then once per clock. Between loads they scramble every sampled input to show that nothing outside a load changes the group.

// File: rtl/pig_pkg.sv
package pig_pkg;

   // Plane resolution codes; the value 3 decodes as the coarse mode
   typedef enum logic [1:0] {
      PM_COARSE = 2'd0,
      PM_MIDDLE = 2'd1,
      PM_FINE   = 2'd2,
      PM_ALIAS  = 2'd3
   } pmode_e;

   localparam int FIELD_MAX = 4;

   // Field width in bits for a mode code
   function automatic logic [2:0] field_width(input logic [1:0] m);
      logic [2:0] w;
      case (pmode_e'(m))
         PM_FINE:   w = 3'd1;
         PM_MIDDLE: w = 3'd2;
         default:   w = 3'd4;
      endcase
      return w;
   endfunction

   // Pen value of slot s taken from one byte under mode m
   function automatic logic [FIELD_MAX-1:0] pen_of(input logic [7:0] b,
                                                   input logic [1:0] m,
                                                   input logic [2:0] s);
      logic [FIELD_MAX-1:0] p;
      logic [2:0] k_hi;
      logic [2:0] k_lo;
      logic [2:0] k_a;
      logic [2:0] k_b;
      p    = '0;
      k_hi = 3'd0;
      k_lo = 3'd0;
      k_a  = 3'd0;
      k_b  = 3'd0;
      case (pmode_e'(m))
         PM_FINE: begin
            k_lo = 3'd7 - s;
            p    = {3'b000, b[k_lo]};
         end
         PM_MIDDLE: begin
            k_hi = 3'd3 - {1'b0, s[2:1]};
            k_lo = 3'd7 - {1'b0, s[2:1]};
            p    = {2'b00, b[k_hi], b[k_lo]};
         end
         default: begin
            k_hi = 3'd1 - {2'b00, s[2]};
            k_a  = 3'd5 - {2'b00, s[2]};
            k_b  = 3'd3 - {2'b00, s[2]};
            k_lo = 3'd7 - {2'b00, s[2]};
            p    = {b[k_hi], b[k_a], b[k_b], b[k_lo]};
         end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/pig_slot_ctr.sv
module pig_slot_ctr #(
   parameter int SLOTS = 8,
   localparam int CNT_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             take,
   output logic [CNT_W-1:0] slot,
   output logic             have
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot <= '0;
         have <= 1'b0;
      end else if (step) begin
         if (take) begin
            slot <= '0;
            have <= 1'b1;
         end else begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
            if (slot == LAST) have <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pig_plane.sv
module pig_plane #(
   parameter int BYTE_W = 8,
   parameter bit ALWAYS_ON = 1'b0,
   localparam int CNT_W = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [1:0]        mode_in,
   input  logic              on_in,
   input  logic [CNT_W-1:0]  slot,
   output logic [3:0]        field,
   output logic [2:0]        width,
   output logic              on_q
);
   import pig_pkg::*;

   logic [BYTE_W-1:0] byte_q;
   logic [1:0]        mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
         mode_q <= 2'd0;
      end else if (take) begin
         byte_q <= byte_in;
         mode_q <= mode_in;
      end
   end

   generate
      if (ALWAYS_ON) begin : g_fixed
         logic unused_on;
         assign unused_on = on_in;
         assign on_q      = 1'b1;
      end else begin : g_switch
         logic on_r;
         always_ff @(posedge clk) begin
            if (!rst_n)    on_r <= 1'b0;
            else if (take) on_r <= on_in;
         end
         assign on_q = on_r;
      end
   endgenerate

   always_comb begin
      if (on_q) begin
         field = pen_of(byte_q, mode_q, slot);
         width = field_width(mode_q);
      end else begin
         field = 4'd0;
         width = 3'd0;
      end
   end

endmodule

// File: rtl/pig_join.sv
module pig_join #(
   parameter int IDX_W = 8
) (
   input  logic [3:0]       a_field,
   input  logic [2:0]       a_width,
   input  logic [3:0]       b_field,
   output logic [IDX_W-1:0] idx
);

   logic [IDX_W-1:0] a_ext;
   logic [IDX_W-1:0] b_ext;
   logic [IDX_W-1:0] b_up;

   assign a_ext = IDX_W'(a_field);
   assign b_ext = IDX_W'(b_field);

   always_comb begin
      case (a_width)
         3'd1:    b_up = b_ext << 1;
         3'd2:    b_up = b_ext << 2;
         default: b_up = b_ext << 4;
      endcase
   end

   assign idx = a_ext | b_up;

endmodule

// File: rtl/pal_index_gen.sv
module pal_index_gen #(
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 8,
   localparam int CNT_W  = $clog2(BYTE_W),
   localparam int PLANES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic              load,
   input  logic [BYTE_W-1:0] plane_a_byte,
   input  logic [BYTE_W-1:0] plane_b_byte,
   input  logic [1:0]        mode_a,
   input  logic [1:0]        mode_b,
   input  logic              plane_b_on,
   output logic [IDX_W-1:0]  pix_index,
   output logic              pix_valid
);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("pal_index_gen: the pixel bit layout needs BYTE_W = 8");
      end
      if (IDX_W < 8) begin : g_bad_idx
         $error("pal_index_gen: IDX_W must hold two 4-bit fields");
      end
   endgenerate

   logic             take;
   logic [CNT_W-1:0] slot_q;
   logic             have_q;
   logic             b_on_q;
   logic [IDX_W-1:0] idx_d;

   logic [PLANES-1:0][BYTE_W-1:0] p_byte;
   logic [PLANES-1:0][1:0]        p_mode;
   logic [PLANES-1:0]             p_on_in;
   logic [PLANES-1:0][3:0]        p_field;
   logic [PLANES-1:0][2:0]        p_width;
   logic [PLANES-1:0]             p_on_q;

   assign take = load & pix_en;

   assign p_byte[0]  = plane_a_byte;
   assign p_byte[1]  = plane_b_byte;
   assign p_mode[0]  = mode_a;
   assign p_mode[1]  = mode_b;
   assign p_on_in[0] = 1'b1;
   assign p_on_in[1] = plane_b_on;

   pig_slot_ctr #(.SLOTS(BYTE_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en),
      .take  (take),
      .slot  (slot_q),
      .have  (have_q)
   );

   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_plane
         pig_plane #(.BYTE_W(BYTE_W), .ALWAYS_ON(p == 0)) u_plane (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take),
            .byte_in (p_byte[p]),
            .mode_in (p_mode[p]),
            .on_in   (p_on_in[p]),
            .slot    (slot_q),
            .field   (p_field[p]),
            .width   (p_width[p]),
            .on_q    (p_on_q[p])
         );
      end
   endgenerate

   assign b_on_q = p_on_q[1];

   logic [2:0] unused_b_width;
   logic       unused_a_on;
   assign unused_b_width = p_width[1];
   assign unused_a_on    = p_on_q[0];

   pig_join #(.IDX_W(IDX_W)) u_join (
      .a_field (p_field[0]),
      .a_width (p_width[0]),
      .b_field (p_field[1]),
      .idx     (idx_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_index <= '0;
         pix_valid <= 1'b0;
      end else if (pix_en) begin
         pix_index <= have_q ? idx_d : '0;
         pix_valid <= have_q;
      end
   end

endmodule

// File: rtl/pal_index_gen_chk.sv
module pal_index_gen_chk #(
   parameter int IDX_W = 8,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_en,
   input logic             load,
   input logic [IDX_W-1:0] pix_index,
   input logic             pix_valid,
   input logic [CNT_W-1:0] slot_q,
   input logic             have_q,
   input logic             b_on_q
);

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ($stable(pix_index) && $stable(pix_valid))); // R3

   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && load) |=> (slot_q == '0 && have_q)); // R2

   AST_LOAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ($stable(slot_q) && $stable(have_q))); // R11

   AST_RUN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !load && slot_q == '1) |=> !have_q); // R10

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> (pix_index == '0)); // R10

   AST_B_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !b_on_q) |=> (pix_index[IDX_W-1:4] == '0)); // R8

endmodule

bind pal_index_gen pal_index_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_en    (pix_en),
   .load      (load),
   .pix_index (pix_index),
   .pix_valid (pix_valid),
   .slot_q    (slot_q),
   .have_q    (have_q),
   .b_on_q    (b_on_q)
);

// File: tb/pal_index_gen_test.sv
`timescale 1ns/1ps
module pal_index_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_en = 1'b0;
   logic       load = 1'b0;
   logic [7:0] a_byte = 8'h00;
   logic [7:0] b_byte = 8'h00;
   logic [1:0] mode_a = 2'd0;
   logic [1:0] mode_b = 2'd0;
   logic       b_on = 1'b0;
   logic [7:0] pix_index;
   logic       pix_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;

   always #4 clk = ~clk;

   pal_index_gen uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pix_en       (pix_en),
      .load         (load),
      .plane_a_byte (a_byte),
      .plane_b_byte (b_byte),
      .mode_a       (mode_a),
      .mode_b       (mode_b),
      .plane_b_on   (b_on),
      .pix_index    (pix_index),
      .pix_valid    (pix_valid)
   );

   // behavioural reference
   function automatic int ref_pen(int b, int m, int s);
      int n;
      if (m == 2) return (b >> (7 - s)) & 1;
      if (m == 1) begin
         n = s / 2;
         return ((b >> (3 - n)) & 1) * 2 + ((b >> (7 - n)) & 1);
      end
      n = s / 4;
      return ((b >> (1 - n)) & 1) * 8 + ((b >> (5 - n)) & 1) * 4 +
             ((b >> (3 - n)) & 1) * 2 + ((b >> (7 - n)) & 1);
   endfunction

   function automatic int ref_width(int m);
      if (m == 2) return 1;
      if (m == 1) return 2;
      return 4;
   endfunction

   int m_a, m_b, m_ma, m_mb, m_on, m_slot, m_have, m_idx, m_val;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_a = 0; m_b = 0; m_ma = 0; m_mb = 0; m_on = 0;
         m_slot = 0; m_have = 0; m_idx = 0; m_val = 0;
      end else if (pix_en) begin
         if (m_have != 0) begin
            m_idx = ref_pen(m_a, m_ma, m_slot);
            if (m_on != 0) m_idx = m_idx + (ref_pen(m_b, m_mb, m_slot) << ref_width(m_ma));
            m_val = 1;
         end else begin
            m_idx = 0;
            m_val = 0;
         end
         if (load) begin
            m_a = a_byte; m_b = b_byte; m_ma = mode_a; m_mb = mode_b; m_on = b_on;
            m_slot = 0; m_have = 1;
         end else begin
            if (m_slot == 7) m_have = 0;
            m_slot = (m_slot + 1) % 8;
         end
      end
   end

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the reference (R1 ordering, R7 join)
   always @(negedge clk) begin
      if (model_on && rst_n && !done) begin
         check(pix_index == m_idx[7:0], "R1/R7 model index", pix_index, m_idx);
         check(pix_valid == m_val[0], "R1 model valid", pix_valid, m_val);
      end
   end

   // load one group, then scramble all sampled inputs (R9) and read 8 slots
   task automatic run_group(input logic [7:0] a, input logic [7:0] b,
                            input logic [1:0] ma, input logic [1:0] mb,
                            input logic on, input logic [63:0] exp, input string tag);
      @(negedge clk);
      a_byte = a; b_byte = b; mode_a = ma; mode_b = mb; b_on = on;
      load = 1'b1; pix_en = 1'b1;
      @(negedge clk);
      load = 1'b0;
      a_byte = ~a; b_byte = ~b; mode_a = ~ma; mode_b = ~mb; b_on = ~on;
      for (int s = 0; s < 8; s++) begin
         @(negedge clk);
         check(pix_index == exp[63 - 8*s -: 8], tag, pix_index, exp[63 - 8*s -: 8]);
         check(pix_valid == 1'b1, {tag, " valid"}, pix_valid, 1);
      end
      @(negedge clk);
      check(pix_valid == 1'b0, "R10 valid after run-out", pix_valid, 0);
      check(pix_index == 8'h00, "R10 index after run-out", pix_index, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(pix_valid == 1'b0, "R12 reset valid", pix_valid, 0);
      check(pix_index == 8'h00, "R12 reset index", pix_index, 0);
      rst_n = 1'b1;
      model_on = 1'b1;

      // R6 both coarse, full 8-bit index
      run_group(8'h80, 8'h40, 2'd0, 2'd0, 1'b1, 64'h0101010110101010, "R6 coarse/coarse");
      // R6 code 3 decodes as coarse
      run_group(8'h80, 8'h40, 2'd3, 2'd3, 1'b1, 64'h0101010110101010, "R6 alias code 3");
      // R5 middle A with coarse B, R7 B shifted by 2
      run_group(8'h88, 8'h02, 2'd1, 2'd0, 1'b1, 64'h2323202000000000, "R5 middle/coarse");
      // R4 fine A with middle B, R7 B shifted by 1
      run_group(8'hF0, 8'h11, 2'd2, 2'd1, 1'b1, 64'h0101010100000606, "R4 fine/middle");
      // R8 plane B off leaves plane A alone
      run_group(8'hA5, 8'hFF, 2'd2, 2'd0, 1'b0, 64'h0100010000010001, "R8 B disabled");
      // R7 fine A with coarse B: 5-bit index
      run_group(8'h01, 8'h80, 2'd2, 2'd0, 1'b1, 64'h0202020200000001, "R7 fine/coarse");

      // R11 load without pix_en is ignored
      @(negedge clk);
      pix_en = 1'b0; load = 1'b1; a_byte = 8'hFF; mode_a = 2'd2; b_on = 1'b0;
      @(negedge clk);
      load = 1'b0; pix_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(pix_valid == 1'b0, "R11 ignored load valid", pix_valid, 0);
      check(pix_index == 8'h00, "R11 ignored load index", pix_index, 0);

      // R3 outputs hold while pix_en is low
      @(negedge clk);
      a_byte = 8'hFF; mode_a = 2'd2; load = 1'b1; pix_en = 1'b1;
      @(negedge clk);
      load = 1'b0;
      @(negedge clk);
      pix_en = 1'b0;
      check(pix_index == 8'h01 && pix_valid, "R3 before hold", pix_index, 1);
      repeat (3) @(negedge clk);
      check(pix_index == 8'h01 && pix_valid, "R3 during hold", pix_index, 1);

      // R2 mid-group reload restarts at slot 0
      pix_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      a_byte = 8'h00; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      @(negedge clk);
      check(pix_index == 8'h00 && pix_valid, "R2 restart slot 0", pix_index, 0);

      // random stream against the model (R1, R2, R3, R7, R9, R10, R11)
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         pix_en = ($urandom % 4) != 0;
         load = ($urandom % 7) == 0;
         a_byte = 8'($urandom);
         b_byte = 8'($urandom);
         mode_a = 2'($urandom);
         mode_b = 2'($urandom);
         b_on = 1'($urandom);
      end
      @(negedge clk);
      pix_en = 1'b0; load = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule